// File: doc/BRIEF.md
# Paired-Register Two-Read One-Write Register File

This block is the general-purpose register file of an execution core whose 64 architectural registers, each 64 bits wide, are stored as 32 even/odd pairs. Register 2k lives in the low half of a 128-bit storage entry and register 2k+1 in its high half. An instruction that needs a two-register operand names the even register and gets the whole entry in one access, so the file needs no third or fourth port and no address incrementer.

The file has two 128-bit read ports and one 128-bit write port. Storage is two identical banks, each with one write port and one read port. Every write lands in both banks, and each read port owns one bank, so the two reads never compete. Each read port requests either a pair or a single register. A single-register read picks a half of the entry using the register number's least significant bit and returns it zero-extended. A write has a byte mask, so a narrow result changes only the bytes it covers.

Reads are synchronous with one cycle of latency. A read that hits the entry being written in the same cycle sees the new bytes merged with the old ones. The storage is not cleared by reset, so software or a bench must write a register before it reads it.

Top module: `pair_regfile`

## Requirements
- R1: A valid pair read of even register n returns {register n+1, register n} on that port's data output one clock after the request, with the lower-numbered register in bits 63:0.
- R2: A valid single read of register n returns register n in bits 63:0 and zero in bits 127:64 one clock later. Even n takes the low half of the entry and odd n takes the high half.
- R3: A valid pair read that names an odd register sets that port's error output one clock later and drives the port's data output to zero. Any valid read that is legal clears the error output.
- R4: The two read ports work independently. Each port can read any register in either mode in the same cycle as the other port, and each returns its own result.
- R5: A completed write is visible through both read ports.
- R6: In pair mode, bit i of the 16-bit write mask enables byte i of the entry (bits 8i+7:8i). A byte whose mask bit is clear keeps its old value.
- R7: A single write of register n stores write-data bits 63:0 into register n, under write-mask bits 7:0 (bit i covers byte i of the register). Mask bits 15:8 and the other register of the pair are not affected.
- R8: A pair write that names an odd register changes no storage. The write-error output is high one clock after that request and low one clock after any other cycle.
- R9: A read of an entry that is written in the same cycle returns the newly written bytes merged with the entry's unwritten bytes.
- R10: While a port's read valid is low, that port's data and error outputs hold the result of its last valid read, even when writes go on.
- R11: After synchronous active-low reset, both data outputs and both error outputs and the write-error output are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| rd0_valid | input | 1 | Read port 0 request |
| rd0_reg | input | 6 | Read port 0 register number |
| rd0_pair | input | 1 | Read port 0 mode: 1 pair, 0 single |
| rd0_data | output | 128 | Read port 0 result |
| rd0_err | output | 1 | Read port 0 odd-pair error |
| rd1_valid | input | 1 | Read port 1 request |
| rd1_reg | input | 6 | Read port 1 register number |
| rd1_pair | input | 1 | Read port 1 mode: 1 pair, 0 single |
| rd1_data | output | 128 | Read port 1 result |
| rd1_err | output | 1 | Read port 1 odd-pair error |
| wr_valid | input | 1 | Write request |
| wr_reg | input | 6 | Write register number |
| wr_pair | input | 1 | Write mode: 1 pair, 0 single |
| wr_data | input | 128 | Write data (single mode uses bits 63:0) |
| wr_be | input | 16 | Write byte mask (single mode uses bits 7:0) |
| wr_err | output | 1 | Odd-pair write error |

## Verification
Faults here stay hidden until the damaged entry is read. A write that misses one bank shows only on the port that owns that bank. A wrong mask or half placement shows as wrong bytes on the next read of that register, which can be many cycles after the write. For this reason the bench keeps a model of every register and compares both ports on every cycle, one clock after each request. A faulty bypass or a faulty hold path shows in the same cycle it occurs, because the bench issues reads and writes to the same entry back to back and also lets idle ports sit while writes go on.

// File: rtl/prf_pkg.sv
// Package: shared defaults and types for the paired register file.
// Assumes registers are grouped in even/odd pairs that share one storage entry.
package prf_pkg;

    // Default geometry of the register file
    localparam int unsigned PRF_REG_W    = 64;
    localparam int unsigned PRF_NUM_REGS = 64;
    localparam int unsigned PRF_RD_PORTS = 2;

    // Operand width selector carried with every access
    typedef enum logic {
        OPW_SINGLE = 1'b0,
        OPW_PAIR   = 1'b1
    } opw_e;

endpackage

// File: rtl/prf_wr_format.sv
// Write formatter: turns a register-level write request into an entry-level
// write (entry index, 128-bit data lane image, 16-bit byte mask).
// Assumes single writes carry their payload in the low register-width bits.
// An odd-based pair write is refused and flagged one cycle later.
module prf_wr_format
    import prf_pkg::*;
#(
    parameter int unsigned REG_W = 64,
    parameter int unsigned NREGS = 64,
    localparam int unsigned RAW  = $clog2(NREGS),
    localparam int unsigned EAW  = RAW - 1,
    localparam int unsigned ENTW = 2 * REG_W,
    localparam int unsigned RBE  = REG_W / 8,
    localparam int unsigned EBE  = ENTW / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_valid,
    input  logic [RAW-1:0]  wr_reg,
    input  logic            wr_pair,
    input  logic [ENTW-1:0] wr_data,
    input  logic [EBE-1:0]  wr_be,
    output logic            ent_we,
    output logic [EAW-1:0]  ent_addr,
    output logic [ENTW-1:0] ent_data,
    output logic [EBE-1:0]  ent_be,
    output logic            wr_err
);

    opw_e width_sel;
    logic odd_pair;

    // Classify the request and reject misaligned pairs
    always_comb begin
        width_sel = opw_e'(wr_pair);
        odd_pair  = (width_sel == OPW_PAIR) && wr_reg[0];
        ent_we    = wr_valid && !odd_pair;
        ent_addr  = wr_reg[RAW-1:1];
    end

    // Place data and mask into the entry lanes
    always_comb begin
        if (width_sel == OPW_PAIR) begin
            ent_data = wr_data;
            ent_be   = wr_be;
        end else if (wr_reg[0]) begin
            ent_data = {wr_data[REG_W-1:0], {REG_W{1'b0}}};
            ent_be   = {wr_be[RBE-1:0], {RBE{1'b0}}};
        end else begin
            ent_data = {{REG_W{1'b0}}, wr_data[REG_W-1:0]};
            ent_be   = {{RBE{1'b0}}, wr_be[RBE-1:0]};
        end
    end

    // Register the refusal flag so it lines up with read results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_err <= 1'b0;
        end else begin
            wr_err <= wr_valid && odd_pair;
        end
    end

endmodule

// File: rtl/prf_bank.sv
// Storage bank: one write port with byte mask, one synchronous read port.
// Assumes the array holds no reset value. The read output register is reset.
// A read of the entry being written returns write-first merged bytes.
module prf_bank #(
    parameter int unsigned ENTW  = 128,
    parameter int unsigned DEPTH = 32,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned NB   = ENTW / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [ENTW-1:0] wdata,
    input  logic [NB-1:0]   wbe,
    input  logic            re,
    input  logic [AW-1:0]   raddr,
    output logic [ENTW-1:0] rdata
);

    logic [ENTW-1:0] mem [DEPTH];
    logic [ENTW-1:0] merged;
    logic            hit;

    // Byte-masked write into the array
    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < NB; b++) begin
                if (wbe[b]) begin
                    mem[waddr][b*8 +: 8] <= wdata[b*8 +: 8];
                end
            end
        end
    end

    // Build the write-first view of the addressed entry
    always_comb begin
        hit    = we && (waddr == raddr);
        merged = mem[raddr];
        for (int b = 0; b < NB; b++) begin
            if (hit && wbe[b]) begin
                merged[b*8 +: 8] = wdata[b*8 +: 8];
            end
        end
    end

    // Capture the read result; hold it while no read is requested
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= merged;
        end
    end

endmodule

// File: rtl/prf_rd_sel.sv
// Read selector for one port: registers the access mode alongside the
// bank read, then returns the whole entry, a zero-extended half, or zero
// for an odd-based pair request (with the error flag set).
// Assumes the bank output updates on the same edges as this port's valid.
module prf_rd_sel
    import prf_pkg::*;
#(
    parameter int unsigned REG_W = 64,
    parameter int unsigned NREGS = 64,
    localparam int unsigned RAW  = $clog2(NREGS),
    localparam int unsigned ENTW = 2 * REG_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid,
    input  logic [RAW-1:0]  reg_num,
    input  logic            pair,
    input  logic [ENTW-1:0] bank_q,
    output logic [ENTW-1:0] data,
    output logic            err
);

    opw_e held_w;
    logic held_hi;
    logic held_err;

    // Keep the mode of the last valid request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_w   <= OPW_SINGLE;
            held_hi  <= 1'b0;
            held_err <= 1'b0;
        end else if (valid) begin
            held_w   <= opw_e'(pair);
            held_hi  <= reg_num[0];
            held_err <= pair && reg_num[0];
        end
    end

    // Pick the half or whole entry to present
    always_comb begin
        err = held_err;
        if (held_err) begin
            data = '0;
        end else if (held_w == OPW_PAIR) begin
            data = bank_q;
        end else if (held_hi) begin
            data = {{REG_W{1'b0}}, bank_q[ENTW-1:REG_W]};
        end else begin
            data = {{REG_W{1'b0}}, bank_q[REG_W-1:0]};
        end
    end

endmodule

// File: rtl/pair_regfile.sv
// Paired-register file top: two read ports, one write port. Each read port
// owns a private copy of the storage, and every write updates all copies.
// Assumes the caller initialises registers before reading them.
module pair_regfile
    import prf_pkg::*;
#(
    parameter int unsigned REG_W = PRF_REG_W,
    parameter int unsigned NREGS = PRF_NUM_REGS,
    localparam int unsigned RAW  = $clog2(NREGS),
    localparam int unsigned EAW  = RAW - 1,
    localparam int unsigned NENT = NREGS / 2,
    localparam int unsigned ENTW = 2 * REG_W,
    localparam int unsigned EBE  = ENTW / 8,
    localparam int unsigned NRP  = PRF_RD_PORTS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd0_valid,
    input  logic [RAW-1:0]  rd0_reg,
    input  logic            rd0_pair,
    output logic [ENTW-1:0] rd0_data,
    output logic            rd0_err,
    input  logic            rd1_valid,
    input  logic [RAW-1:0]  rd1_reg,
    input  logic            rd1_pair,
    output logic [ENTW-1:0] rd1_data,
    output logic            rd1_err,
    input  logic            wr_valid,
    input  logic [RAW-1:0]  wr_reg,
    input  logic            wr_pair,
    input  logic [ENTW-1:0] wr_data,
    input  logic [EBE-1:0]  wr_be,
    output logic            wr_err
);

    logic            ent_we;
    logic [EAW-1:0]  ent_addr;
    logic [ENTW-1:0] ent_data;
    logic [EBE-1:0]  ent_be;

    logic            p_valid [NRP];
    logic [RAW-1:0]  p_reg   [NRP];
    logic            p_pair  [NRP];
    logic [ENTW-1:0] p_q     [NRP];
    logic [ENTW-1:0] p_data  [NRP];
    logic            p_err   [NRP];

    // Gather the scalar read ports into per-port arrays
    always_comb begin
        p_valid[0] = rd0_valid;
        p_reg[0]   = rd0_reg;
        p_pair[0]  = rd0_pair;
        p_valid[1] = rd1_valid;
        p_reg[1]   = rd1_reg;
        p_pair[1]  = rd1_pair;
    end

    // Drive the scalar read results
    always_comb begin
        rd0_data = p_data[0];
        rd0_err  = p_err[0];
        rd1_data = p_data[1];
        rd1_err  = p_err[1];
    end

    prf_wr_format #(
        .REG_W (REG_W),
        .NREGS (NREGS)
    ) u_wfmt (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_reg   (wr_reg),
        .wr_pair  (wr_pair),
        .wr_data  (wr_data),
        .wr_be    (wr_be),
        .ent_we   (ent_we),
        .ent_addr (ent_addr),
        .ent_data (ent_data),
        .ent_be   (ent_be),
        .wr_err   (wr_err)
    );

    for (genvar p = 0; p < NRP; p++) begin : g_port
        prf_bank #(
            .ENTW  (ENTW),
            .DEPTH (NENT)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (ent_we),
            .waddr (ent_addr),
            .wdata (ent_data),
            .wbe   (ent_be),
            .re    (p_valid[p]),
            .raddr (p_reg[p][RAW-1:1]),
            .rdata (p_q[p])
        );

        prf_rd_sel #(
            .REG_W (REG_W),
            .NREGS (NREGS)
        ) u_sel (
            .clk     (clk),
            .rst_n   (rst_n),
            .valid   (p_valid[p]),
            .reg_num (p_reg[p]),
            .pair    (p_pair[p]),
            .bank_q  (p_q[p]),
            .data    (p_data[p]),
            .err     (p_err[p])
        );
    end

endmodule

// File: rtl/prf_checker.sv
// Checker for the paired register file: port-level temporal properties.
// Assumes synchronous active-low reset; all properties are off during reset.
module prf_checker #(
    parameter int unsigned RAW  = 6,
    parameter int unsigned ENTW = 128
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rd0_valid,
    input logic [RAW-1:0]  rd0_reg,
    input logic            rd0_pair,
    input logic [ENTW-1:0] rd0_data,
    input logic            rd0_err,
    input logic            rd1_valid,
    input logic [RAW-1:0]  rd1_reg,
    input logic            rd1_pair,
    input logic [ENTW-1:0] rd1_data,
    input logic            rd1_err,
    input logic            wr_valid,
    input logic [RAW-1:0]  wr_reg,
    input logic            wr_pair,
    input logic            wr_err
);
    localparam int unsigned HW = ENTW / 2;

    // Odd-based pair read raises the error one clock later
    assert_rd0_err_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd0_valid) |-> (rd0_err == $past(rd0_pair && rd0_reg[0])));
    assert_rd1_err_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd1_valid) |-> (rd1_err == $past(rd1_pair && rd1_reg[0])));

    // An error result carries no data
    assert_rd0_err_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd0_err |-> (rd0_data == '0));

    // Single reads are zero-extended
    assert_rd0_single_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd0_valid && !rd0_pair) |-> (rd0_data[ENTW-1:HW] == '0));
    assert_rd1_single_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd1_valid && !rd1_pair) |-> (rd1_data[ENTW-1:HW] == '0));

    // Idle ports hold their last result
    assert_rd0_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd0_valid) |-> ($stable(rd0_data) && $stable(rd0_err)));
    assert_rd1_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd1_valid) |-> ($stable(rd1_data) && $stable(rd1_err)));

    // Refused writes are flagged one clock later
    assert_wr_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err == $past(wr_valid && wr_pair && wr_reg[0]));

endmodule

bind pair_regfile prf_checker #(
    .RAW  (RAW),
    .ENTW (ENTW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd0_valid (rd0_valid),
    .rd0_reg   (rd0_reg),
    .rd0_pair  (rd0_pair),
    .rd0_data  (rd0_data),
    .rd0_err   (rd0_err),
    .rd1_valid (rd1_valid),
    .rd1_reg   (rd1_reg),
    .rd1_pair  (rd1_pair),
    .rd1_data  (rd1_data),
    .rd1_err   (rd1_err),
    .wr_valid  (wr_valid),
    .wr_reg    (wr_reg),
    .wr_pair   (wr_pair),
    .wr_err    (wr_err)
);

// File: tb/sim_pair_regfile.sv
// Bench: behavioural register model updated on each rising edge and
// compared with every output on each falling edge.
module sim_pair_regfile;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rd0_valid = 1'b0, rd1_valid = 1'b0;
    logic [5:0]   rd0_reg = '0, rd1_reg = '0;
    logic         rd0_pair = 1'b0, rd1_pair = 1'b0;
    logic [127:0] rd0_data, rd1_data;
    logic         rd0_err, rd1_err;
    logic         wr_valid = 1'b0;
    logic [5:0]   wr_reg = '0;
    logic         wr_pair = 1'b0;
    logic [127:0] wr_data = '0;
    logic [15:0]  wr_be = '0;
    logic         wr_err;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    bit    chk_en = 1'b0;
    string cur_req = "R11";

    // Reference state
    logic [63:0]  regs [64];
    logic [127:0] exp_d [2];
    logic         exp_e [2];
    logic         exp_we;

    always #5 clk = ~clk;

    pair_regfile u0 (
        .clk(clk), .rst_n(rst_n),
        .rd0_valid(rd0_valid), .rd0_reg(rd0_reg), .rd0_pair(rd0_pair),
        .rd0_data(rd0_data), .rd0_err(rd0_err),
        .rd1_valid(rd1_valid), .rd1_reg(rd1_reg), .rd1_pair(rd1_pair),
        .rd1_data(rd1_data), .rd1_err(rd1_err),
        .wr_valid(wr_valid), .wr_reg(wr_reg), .wr_pair(wr_pair),
        .wr_data(wr_data), .wr_be(wr_be), .wr_err(wr_err)
    );

    function automatic logic [127:0] model_read(input logic [5:0] r, input logic pr);
        if (pr) return {regs[r + 6'd1], regs[r]};
        return {64'd0, regs[r]};
    endfunction

    // Model: apply the write first, then evaluate reads (write-first)
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_d[0] = '0; exp_d[1] = '0;
            exp_e[0] = 1'b0; exp_e[1] = 1'b0;
            exp_we = 1'b0;
        end else begin
            exp_we = wr_valid && wr_pair && wr_reg[0];
            if (wr_valid && !exp_we) begin
                if (wr_pair) begin
                    for (int b = 0; b < 16; b++)
                        if (wr_be[b]) regs[wr_reg + 6'(b / 8)][(b % 8) * 8 +: 8] = wr_data[b * 8 +: 8];
                end else begin
                    for (int b = 0; b < 8; b++)
                        if (wr_be[b]) regs[wr_reg][b * 8 +: 8] = wr_data[b * 8 +: 8];
                end
            end
            if (rd0_valid) begin
                exp_e[0] = rd0_pair && rd0_reg[0];
                exp_d[0] = exp_e[0] ? 128'd0 : model_read(rd0_reg, rd0_pair);
            end
            if (rd1_valid) begin
                exp_e[1] = rd1_pair && rd1_reg[0];
                exp_d[1] = exp_e[1] ? 128'd0 : model_read(rd1_reg, rd1_pair);
            end
        end
    end

    task automatic cmp(input string what, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
        end
    endtask

    // Compare every output on the falling edge
    always @(negedge clk) begin
        if (chk_en && !done) begin
            cmp("rd0_data", rd0_data, exp_d[0]);
            cmp("rd0_err", {127'd0, rd0_err}, {127'd0, exp_e[0]});
            cmp("rd1_data", rd1_data, exp_d[1]);
            cmp("rd1_err", {127'd0, rd1_err}, {127'd0, exp_e[1]});
            cmp("wr_err", {127'd0, wr_err}, {127'd0, exp_we});
        end
    end

    task automatic idle();
        rd0_valid = 1'b0; rd1_valid = 1'b0; wr_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] r, input logic pr, input logic [127:0] d, input logic [15:0] be);
        wr_valid = 1'b1; wr_reg = r; wr_pair = pr; wr_data = d; wr_be = be;
    endtask

    task automatic rd(input int p, input logic [5:0] r, input logic pr);
        if (p == 0) begin rd0_valid = 1'b1; rd0_reg = r; rd0_pair = pr; end
        else        begin rd1_valid = 1'b1; rd1_reg = r; rd1_pair = pr; end
    endtask

    task automatic step();
        @(negedge clk);
        rd0_valid = 1'b0; rd1_valid = 1'b0; wr_valid = 1'b0;
    endtask

    function automatic logic [127:0] pat(input int k);
        return {32'(k * 32'h9E3779B1), 32'(k ^ 32'h5A5A1234), 32'(k * 7 + 3), 32'hC0DE0000 + 32'(k)};
    endfunction

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_en = 1'b1;
        // R11: outputs zero after reset
        cur_req = "R11";
        @(negedge clk);
        // Initialise every entry with pair writes
        cur_req = "R5";
        for (int e = 0; e < 32; e++) begin
            wr(6'(2 * e), 1'b1, pat(e), 16'hFFFF);
            step();
        end
        // R1: pair reads on both ports
        cur_req = "R1";
        for (int e = 0; e < 32; e++) begin
            rd(0, 6'(2 * e), 1'b1);
            rd(1, 6'(62 - 2 * e), 1'b1);
            step();
        end
        // R2: single reads, even and odd
        cur_req = "R2";
        for (int r = 0; r < 64; r++) begin
            rd(0, 6'(r), 1'b0);
            rd(1, 6'(r ^ 1), 1'b0);
            step();
        end
        // R3: odd pair reads, then recovery
        cur_req = "R3";
        rd(0, 6'd5, 1'b1); rd(1, 6'd63, 1'b1); step();
        idle();
        rd(0, 6'd4, 1'b1); rd(1, 6'd7, 1'b0); step();
        // R4: independent mixed-mode reads, same and different registers
        cur_req = "R4";
        for (int k = 0; k < 40; k++) begin
            rd(0, 6'($urandom_range(63)), 1'($urandom_range(1)));
            rd(1, 6'($urandom_range(63)), 1'($urandom_range(1)));
            step();
        end
        rd(0, 6'd20, 1'b1); rd(1, 6'd20, 1'b1); step();
        // R5: a write observed on both ports
        cur_req = "R5";
        wr(6'd10, 1'b1, {64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444}, 16'hFFFF); step();
        rd(0, 6'd10, 1'b1); rd(1, 6'd11, 1'b0); step();
        // R6: partial byte masks in pair mode
        cur_req = "R6";
        wr(6'd12, 1'b1, {128{1'b1}}, 16'h8421); step();
        rd(0, 6'd12, 1'b1); rd(1, 6'd12, 1'b1); step();
        wr(6'd12, 1'b1, 128'd0, 16'h0000); step();
        rd(0, 6'd12, 1'b1); step();
        // R7: single writes touch only the addressed register
        cur_req = "R7";
        wr(6'd21, 1'b0, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF}, 16'hFFFF); step();
        rd(0, 6'd20, 1'b1); rd(1, 6'd21, 1'b0); step();
        wr(6'd20, 1'b0, {64'hFFFF_FFFF_FFFF_FFFF, 64'hFEDC_BA98_7654_3210}, 16'hFF0F); step();
        rd(0, 6'd20, 1'b1); rd(1, 6'd20, 1'b0); step();
        // R8: odd pair write refused, storage unchanged
        cur_req = "R8";
        wr(6'd31, 1'b1, {128{1'b1}}, 16'hFFFF); step();
        rd(0, 6'd30, 1'b1); rd(1, 6'd32, 1'b1); step();
        // R9: read and write the same entry in one cycle
        cur_req = "R9";
        wr(6'd40, 1'b1, {128{1'b0}}, 16'h00F0); rd(0, 6'd40, 1'b1); rd(1, 6'd41, 1'b0); step();
        wr(6'd41, 1'b0, 128'h5555_6666_7777_8888, 16'h00FF); rd(0, 6'd40, 1'b1); rd(1, 6'd41, 1'b0); step();
        for (int k = 0; k < 20; k++) begin
            wr(6'(2 * $urandom_range(31)), 1'b1, pat(k + 100), 16'($urandom_range(65535)));
            rd(0, wr_reg, 1'b1); rd(1, 6'(wr_reg + 6'd1), 1'b0);
            step();
        end
        // R10: idle ports hold while writes continue
        cur_req = "R10";
        rd(0, 6'd2, 1'b1); rd(1, 6'd3, 1'b0); step();
        for (int k = 0; k < 8; k++) begin
            wr(6'd2, 1'b1, pat(k + 200), 16'hFFFF); step();
        end
        rd(0, 6'd2, 1'b1); step();
        idle(); idle();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule